// File: doc/BRIEF.md
# Prescaled Multi-Timer Bank with Watchdog

This block holds one clock prescaler and a parameterised set of down-counting timers, from one to seven. The prescaler counts system clocks and emits a single-cycle tick each time it wraps. It is normally programmed so that the tick arrives at 1 MHz. Every enabled timer steps down once per tick. When a timer passes below zero it pulses an interrupt, and then it either restarts from its reload value or switches itself off.

Interrupts are placed on a vector of interrupt lines. Timer 0 drives a base line, and each following timer drives the next line up. When separate interrupts are turned off, every timer drives the base line. The highest-numbered timer can be built as a watchdog. That timer leaves reset already loaded with a time-out value and already counting, and when it expires it sets a sticky watchdog output. Software reaches the prescaler and the timers through a flat word-addressed register port with registered read data.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, `irq_o` and `wdog_o` are zero. Both prescaler registers hold `PRESC_RST`. Every ordinary timer has counter, reload and control equal to zero.
- R2: Each clock, the prescaler counter decrements by one. When the counter is zero it instead reloads from the prescaler reload register and raises the internal tick for one cycle, so a reload value P gives a tick every P+1 clocks.
- R3: An enabled timer with counter R underflows on the R+1-th tick. With the prescaler counter written to P in the cycle before the timer's control write (enable and load set), the timer's interrupt line is high in the 1+(P+1)(R+1)-th cycle after the control write and only in that cycle.
- R4: If auto-reload (control bit 1) is set, the timer reloads on underflow and keeps running, so consecutive interrupts are (P+1)(R+1) cycles apart.
- R5: If auto-reload is clear, the timer clears its enable (control bit 0) on underflow. Its counter wraps to all ones, and no further interrupt follows.
- R6: Writing control bit 2 (load) copies the reload register into the counter in the same cycle. The load bit always reads back as zero, and a timer whose enable is clear holds its counter.
- R7: With separate interrupts enabled, timer i drives `irq_o[IRQ_BASE+i]`, and all other lines stay low.
- R8: With separate interrupts disabled, every timer drives `irq_o[IRQ_BASE]` only.
- R9: With `WDOG_EN` set, the last timer leaves reset with counter and reload equal to `WDOG_INIT` and enable set. `wdog_o` rises (Pr+1)(WDOG_INIT+1)+2 cycles after reset release and stays high until a control write with the load bit set reaches that timer.
- R10: Register map, by word address: 0 = prescaler counter, 1 = prescaler reload, 4(i+1)+0/1/2 = timer i counter/reload/control. `reg_rdata` shows the addressed register one cycle after `reg_sel` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | ADDR_W | Word address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_o | output | IRQ_LINES | Interrupt line vector, one-cycle pulses |
| wdog_o | output | 1 | Sticky watchdog expiry flag |

## Verification
Read data arrives one cycle after the address is presented. An interrupt line pulses 1+(P+1)(R+1) cycles after the control write, provided the prescaler counter was written to P in the cycle before that write. The watchdog flag rises (Pr+1)(W+1)+2 cycles after reset release. The bench runs a free-running cycle count and samples every output on the falling edge. For each result it records the count at which the output first changes and compares it with the formula, and it checks both the cycle before and the cycle after each pulse. A second instance built with a shared interrupt line runs on the same register traffic, so the two line placements are compared in the same cycle.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  // control word layout
  localparam int CTL_EN   = 0;
  localparam int CTL_AUTO = 1;
  localparam int CTL_LOAD = 2;

  typedef struct packed {
    logic load;
    logic auto_rl;
    logic en;
  } ctl_t;

  // word offsets inside a four-word slot
  localparam logic [1:0] OFS_CNT = 2'd0;
  localparam logic [1:0] OFS_RLD = 2'd1;
  localparam logic [1:0] OFS_CTL = 2'd2;
endpackage

// File: rtl/ttb_prescaler.sv
module ttb_prescaler #(
  parameter int W       = 8,
  parameter int RST_RLD = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_we_i,
  input  logic         rld_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, rld_q;
  logic         tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= W'(RST_RLD);
      rld_q  <= W'(RST_RLD);
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (rld_we_i) rld_q <= wdata_i;
      if (cnt_we_i) begin
        cnt_q <= wdata_i;
      end else if (cnt_q == '0) begin
        cnt_q  <= rld_q;
        tick_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/ttb_timer.sv
module ttb_timer import ttb_pkg::*; #(
  parameter int W         = 16,
  parameter bit IS_WDOG   = 1'b0,
  parameter int WDOG_INIT = 1000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         cnt_we_i,
  input  logic         rld_we_i,
  input  logic         ctl_we_i,
  input  logic [W-1:0] wdata_i,
  input  ctl_t         ctl_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         en_o,
  output logic         auto_o,
  output logic         uflow_o
);
  localparam logic [W-1:0] INIT_VAL = IS_WDOG ? W'(WDOG_INIT) : '0;

  logic [W-1:0] cnt_q, rld_q;
  logic         en_q, auto_q, uflow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= INIT_VAL;
      rld_q   <= INIT_VAL;
      en_q    <= IS_WDOG;
      auto_q  <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      uflow_q <= 1'b0;
      if (rld_we_i) rld_q <= wdata_i;
      if (ctl_we_i) begin
        en_q   <= ctl_i.en;
        auto_q <= ctl_i.auto_rl;
      end
      // load beats a counter write, which beats counting
      if (ctl_we_i && ctl_i.load) begin
        cnt_q <= rld_q;
      end else if (cnt_we_i) begin
        cnt_q <= wdata_i;
      end else if (en_q && tick_i) begin
        if (cnt_q == '0) begin
          uflow_q <= 1'b1;
          if (auto_q) cnt_q <= rld_q;
          else begin
            cnt_q <= cnt_q - 1'b1;
            if (!ctl_we_i) en_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign rld_o   = rld_q;
  assign en_o    = en_q;
  assign auto_o  = auto_q;
  assign uflow_o = uflow_q;
endmodule

// File: rtl/ttb_irq_route.sv
module ttb_irq_route #(
  parameter int N     = 3,
  parameter int LINES = 16,
  parameter int BASE  = 8,
  parameter bit SEP   = 1'b1
) (
  input  logic [N-1:0]     uflow_i,
  output logic [LINES-1:0] lines_o
);
  if (SEP) begin : g_sep
    always_comb begin
      lines_o = '0;
      lines_o[BASE +: N] = uflow_i;
    end
  end else begin : g_shared
    always_comb begin
      lines_o = '0;
      lines_o[BASE] = |uflow_i;
    end
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank import ttb_pkg::*; #(
  parameter int NUM_TIMERS = 3,
  parameter int PRESC_W    = 8,
  parameter int TMR_W      = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int IRQ_LINES  = 16,
  parameter int IRQ_BASE   = 8,
  parameter bit SEP_IRQ    = 1'b1,
  parameter bit WDOG_EN    = 1'b1,
  parameter int WDOG_INIT  = 1000,
  parameter int PRESC_RST  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    reg_sel,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [IRQ_LINES-1:0] irq_o,
  output logic                 wdog_o
);
  localparam int SLOT_W = ADDR_W - 2;
  localparam int LAST   = NUM_TIMERS - 1;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        ofs;
  assign slot = reg_sel[ADDR_W-1:2];
  assign ofs  = reg_sel[1:0];

  // prescaler
  logic               tick;
  logic [PRESC_W-1:0] ps_cnt, ps_rld;
  logic               ps_cnt_we, ps_rld_we;
  assign ps_cnt_we = reg_wr && (slot == '0) && (ofs == OFS_CNT);
  assign ps_rld_we = reg_wr && (slot == '0) && (ofs == OFS_RLD);

  ttb_prescaler #(.W(PRESC_W), .RST_RLD(PRESC_RST)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .cnt_we_i (ps_cnt_we),
    .rld_we_i (ps_rld_we),
    .wdata_i  (reg_wdata[PRESC_W-1:0]),
    .cnt_o    (ps_cnt),
    .rld_o    (ps_rld),
    .tick_o   (tick)
  );

  // timers
  logic [TMR_W-1:0]      t_cnt [NUM_TIMERS];
  logic [TMR_W-1:0]      t_rld [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] t_en, t_auto, t_uflow;
  ctl_t                  ctl_w;
  assign ctl_w = ctl_t'(reg_wdata[2:0]);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(i + 1);
    logic hit;
    assign hit = reg_wr && (slot == MY_SLOT);

    ttb_timer #(
      .W         (TMR_W),
      .IS_WDOG   (WDOG_EN && (i == LAST)),
      .WDOG_INIT (WDOG_INIT)
    ) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (tick),
      .cnt_we_i (hit && (ofs == OFS_CNT)),
      .rld_we_i (hit && (ofs == OFS_RLD)),
      .ctl_we_i (hit && (ofs == OFS_CTL)),
      .wdata_i  (reg_wdata[TMR_W-1:0]),
      .ctl_i    (ctl_w),
      .cnt_o    (t_cnt[i]),
      .rld_o    (t_rld[i]),
      .en_o     (t_en[i]),
      .auto_o   (t_auto[i]),
      .uflow_o  (t_uflow[i])
    );
  end

  // read path
  logic [DATA_W-1:0] rd_mux, rdata_q;
  always_comb begin
    rd_mux = '0;
    if (slot == '0) begin
      case (ofs)
        OFS_CNT: rd_mux = DATA_W'(ps_cnt);
        OFS_RLD: rd_mux = DATA_W'(ps_rld);
        default: rd_mux = '0;
      endcase
    end
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (slot == SLOT_W'(i + 1)) begin
        case (ofs)
          OFS_CNT: rd_mux = DATA_W'(t_cnt[i]);
          OFS_RLD: rd_mux = DATA_W'(t_rld[i]);
          OFS_CTL: rd_mux = DATA_W'({t_auto[i], t_en[i]});
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end
  assign reg_rdata = rdata_q;

  // interrupt placement
  logic [IRQ_LINES-1:0] irq_next, irq_q;
  ttb_irq_route #(
    .N(NUM_TIMERS), .LINES(IRQ_LINES), .BASE(IRQ_BASE), .SEP(SEP_IRQ)
  ) u_route (
    .uflow_i (t_uflow),
    .lines_o (irq_next)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_next;
  end
  assign irq_o = irq_q;

  // watchdog flag
  if (WDOG_EN) begin : g_wdog
    localparam logic [SLOT_W-1:0] WD_SLOT = SLOT_W'(NUM_TIMERS);
    logic wd_q, wd_clr;
    assign wd_clr = reg_wr && (slot == WD_SLOT) && (ofs == OFS_CTL) && ctl_w.load;
    always_ff @(posedge clk) begin
      if (rst) wd_q <= 1'b0;
      else     wd_q <= (wd_q && !wd_clr) || t_uflow[LAST];
    end
    assign wdog_o = wd_q;
  end else begin : g_nowdog
    assign wdog_o = 1'b0;
  end
endmodule

// File: rtl/ttb_chk.sv
module ttb_chk #(
  parameter int NUM_TIMERS = 3,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int PRESC_W    = 8,
  parameter int IRQ_LINES  = 16,
  parameter int IRQ_BASE   = 8,
  parameter bit SEP_IRQ    = 1'b1,
  parameter bit WDOG_EN    = 1'b1
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     reg_sel,
  input logic                  reg_wr,
  input logic [DATA_W-1:0]     reg_wdata,
  input logic [IRQ_LINES-1:0]  irq_o,
  input logic                  wdog_o,
  input logic                  tick,
  input logic [PRESC_W-1:0]    ps_rld,
  input logic [NUM_TIMERS-1:0] t_uflow,
  input logic [NUM_TIMERS-1:0] t_en,
  input logic [NUM_TIMERS-1:0] t_auto
);
  localparam logic [IRQ_LINES-1:0] OK_MASK = SEP_IRQ ?
    (IRQ_LINES'((1 << NUM_TIMERS) - 1) << IRQ_BASE) : (IRQ_LINES'(1) << IRQ_BASE);

  // R7 / R8: nothing outside the allotted lines
  p_idle_lines_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_o & ~OK_MASK) == '0);

  // R2: with a non-zero reload the tick never repeats back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && ($past(ps_rld) != '0)) |=> !tick);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_t
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'((i + 1) * 4 + 2);
    // R5: one-shot timer drops its enable at underflow
    p_oneshot_off_r5: assert property (@(posedge clk) disable iff (rst)
      (t_uflow[i] && !$past(t_auto[i]) && !($past(reg_wr) && ($past(reg_sel) == CTL_A)))
      |-> !t_en[i]);
    if (SEP_IRQ) begin : g_sep
      // R7: underflow of timer i shows on its own line next cycle
      p_irq_line_r7: assert property (@(posedge clk) disable iff (rst)
        t_uflow[i] |=> irq_o[IRQ_BASE + i]);
    end else begin : g_sh
      // R8: any underflow shows on the base line
      p_irq_shared_r8: assert property (@(posedge clk) disable iff (rst)
        t_uflow[i] |=> irq_o[IRQ_BASE]);
    end
  end

  if (WDOG_EN) begin : g_wd
    localparam logic [ADDR_W-1:0] WD_CTL_A = ADDR_W'(NUM_TIMERS * 4 + 2);
    // R9: watchdog expiry sets the flag
    p_wdog_set_r9: assert property (@(posedge clk) disable iff (rst)
      t_uflow[NUM_TIMERS-1] |=> wdog_o);
    // R9: flag only clears through a load write to the watchdog
    p_wdog_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (wdog_o && !(reg_wr && (reg_sel == WD_CTL_A) && reg_wdata[2])) |=> wdog_o);
  end
endmodule

bind tick_timer_bank ttb_chk #(
  .NUM_TIMERS (NUM_TIMERS),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .PRESC_W    (PRESC_W),
  .IRQ_LINES  (IRQ_LINES),
  .IRQ_BASE   (IRQ_BASE),
  .SEP_IRQ    (SEP_IRQ),
  .WDOG_EN    (WDOG_EN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .irq_o     (irq_o),
  .wdog_o    (wdog_o),
  .tick      (tick),
  .ps_rld    (ps_rld),
  .t_uflow   (t_uflow),
  .t_en      (t_en),
  .t_auto    (t_auto)
);

// File: tb/tb_tick_timer_bank.sv
`timescale 1ns/1ps
module tb_tick_timer_bank;
  localparam int WD_INIT = 20;
  localparam int PR_RST  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_sh;
  logic [15:0] irq, irq_sh;
  logic        wdog, wdog_sh;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int first_wd = -1;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer_bank #(.NUM_TIMERS(3), .WDOG_INIT(WD_INIT), .PRESC_RST(PR_RST)) dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .irq_o(irq), .wdog_o(wdog));

  tick_timer_bank #(.NUM_TIMERS(2), .SEP_IRQ(1'b0), .WDOG_EN(1'b0),
                    .WDOG_INIT(WD_INIT), .PRESC_RST(PR_RST)) dut_sh (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_sh), .irq_o(irq_sh), .wdog_o(wdog_sh));

  always @(negedge clk) if (!rst && wdog && first_wd < 0) first_wd = cyc;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
  endtask

  task automatic mark(output int c0);
    @(negedge clk);
    reg_wr = 1'b0;
    c0 = cyc;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_sel = a; reg_wr = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wait_irq(input int b, input int limit, output int at);
    at = -1;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (irq[b]) begin at = cyc; break; end
    end
  endtask

  task automatic t_reset_and_wdog();
    logic [31:0] v;
    int cz;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cz = cyc;
    check("R1 irq after reset", 32'(irq), 32'h0);
    check("R1 wdog after reset", 32'(wdog), 32'h0);
    rd(5'd1, v);  check("R1 R10 prescaler reload", v, 32'(PR_RST));
    rd(5'd6, v);  check("R1 timer0 control", v, 32'h0);
    rd(5'd5, v);  check("R1 timer0 reload", v, 32'h0);
    rd(5'd14, v); check("R9 watchdog enabled at reset", v, 32'h1);
    rd(5'd13, v); check("R9 watchdog reload", v, 32'(WD_INIT));
    for (int k = 0; k < 400 && first_wd < 0; k++) @(negedge clk);
    check("R9 watchdog expiry cycle", 32'(first_wd - cz), 32'((PR_RST + 1) * (WD_INIT + 1) + 2));
    repeat (10) @(negedge clk);
    check("R9 watchdog flag sticky", 32'(wdog), 32'h1);
    wr(5'd14, 32'h4);
    mark(cz);
    check("R9 watchdog flag cleared by load", 32'(wdog), 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    int c0, at, extra;
    wr(5'd1, 32'd2);
    wr(5'd5, 32'd5);
    wr(5'd0, 32'd2);
    wr(5'd6, 32'h5);
    mark(c0);
    wait_irq(8, 200, at);
    check("R3 one-shot interrupt cycle", 32'(at - c0), 32'(3 * 6 + 1));
    check("R7 only timer0 line", 32'(irq), 32'h0100);
    @(negedge clk);
    check("R3 interrupt is one cycle", 32'(irq[8]), 32'h0);
    rd(5'd6, v); check("R5 enable self-cleared", v, 32'h0);
    rd(5'd4, v); check("R5 counter wrapped", v, 32'h0000FFFF);
    extra = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (irq[8]) extra++;
    end
    check("R5 no repeat interrupt", 32'(extra), 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    int c0;
    wr(5'd5, 32'd100);
    wr(5'd6, 32'h4);
    mark(c0);
    rd(5'd4, v); check("R6 load copies reload", v, 32'd100);
    rd(5'd6, v); check("R6 load bit reads zero", v, 32'h0);
    repeat (20) @(negedge clk);
    rd(5'd4, v); check("R6 disabled timer holds", v, 32'd100);
  endtask

  task automatic t_autoreload();
    int c0, at1, at2;
    wr(5'd1, 32'd1);
    wr(5'd9, 32'd3);
    wr(5'd0, 32'd1);
    wr(5'd10, 32'h7);
    mark(c0);
    wait_irq(9, 200, at1);
    check("R3 R2 auto timer first interrupt", 32'(at1 - c0), 32'(2 * 4 + 1));
    check("R7 timer1 on base+1", 32'(irq), 32'h0200);
    check("R8 shared instance on base line", 32'(irq_sh), 32'h0100);
    @(negedge clk);
    check("R4 pulse ends", 32'(irq[9]), 32'h0);
    wait_irq(9, 200, at2);
    check("R4 reload period", 32'(at2 - at1), 32'(2 * 4));
    wr(5'd10, 32'h0);
    mark(c0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset_and_wdog();
    t_oneshot();
    t_load();
    t_autoreload();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule